// File: doc/BRIEF.md
# Two-Clock Register Bridge with Per-Register Write Synchronization

This block is a small register bank split across two clock domains. A bus port on the system clock accepts single-beat reads and writes. A set of synchronized registers keeps its working copy in the peripheral clock domain. Every bus write to one of those registers is carried across by its own toggle handshake. Some of the synchronized registers are also marked for read synchronization. Reading one of them starts a capture of the core-side value into a bus-side shadow. A few plain registers exist only in the bus domain and respond with no crossing.

Each synchronized register has its own busy bit, which stays set while that register's crossing is in flight. A write to a register whose busy bit is set is discarded and raises a one-cycle access-error pulse. When the whole busy bitmap drops from non-zero to zero, a sync-ready flag sets. The flag stays set until the bus writes a one to it. Core-side logic can also load a synchronized register directly, so that values produced by the peripheral can be read back through the read path.

The request port has valid/ready signals, but ready is tied high, so the bridge never applies back-pressure. Every request presented with valid is taken on that edge. A read answers with a single-cycle response strobe on the next edge. There is no ready on the response side, so the requester must always be able to accept it.

Top module: `wsync_reg_bridge`

## Requirements
- R1: A bus write to synchronized register i (address i, 0 <= i < NSYNC) whose busy bit is clear sets busy[i] from the edge after acceptance. busy[i] stays set until the written value appears on the core copy of register i (core_regs slice i). It then clears without further bus activity.
- R2: A bus write to a synchronized register whose busy bit is set is discarded, so the core copy keeps the value of the earlier write. The edge after acceptance raises access_err for exactly that one cycle.
- R3: sync_ready (also readable at address 2**AW-1, bit 0) sets only when busy goes from non-zero to all zeros. A write to that address with bit 0 equal to 1 clears it. A write with bit 0 equal to 0 leaves it unchanged.
- R4: A read of a read-synchronized register returns the current bus-side shadow and starts a capture of the core value, which sets busy for that register. After busy clears, a later read returns the captured core value. A read of a write-only synchronized register returns the last value accepted for it and sets no busy bit.
- R5: A read-synchronized register uses one busy bit for both directions. A write that arrives while its read capture is in flight is discarded and flagged as in R2.
- R6: The bus-only registers at addresses NSYNC to NSYNC+NLOCAL-1 store writes and return them on the next read. Accessing them never sets a busy bit.
- R7: Crossings on different synchronized registers run at the same time, and each one completes on its own.
- R8: The busy bitmap can be read at address 2**AW-2, in bits NSYNC-1:0.
- R9: After reset, busy, access_err, sync_ready and rsp_valid are 0 and every core copy is 0.
- R10: req_ready is always 1. Every accepted read gives rsp_valid high for one cycle on the next edge, with rsp_data valid alongside it.
- R11: A core_ld[i] pulse in the core domain loads core_ld_data slice i into the core copy of register i, unless a bus write lands on that register in the same core cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | System (bus-side) clock |
| bus_rst_n | input | 1 | Active-low reset, bus domain |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready (constant 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Register address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Read response strobe |
| rsp_data | output | DW | Read response data |
| busy | output | NSYNC | Per-register crossing in flight |
| access_err | output | 1 | One-cycle pulse for a discarded write |
| sync_ready | output | 1 | All crossings finished (sticky, write-one-to-clear) |
| core_clk | input | 1 | Peripheral clock |
| core_rst_n | input | 1 | Active-low reset, core domain |
| core_ld | input | NSYNC | Core-side load strobe per register |
| core_ld_data | input | NSYNC*DW | Core-side load values, slice i for register i |
| core_regs | output | NSYNC*DW | Core-domain copies of the synchronized registers |

## Verification
The hardest case to reach is a collision on one busy bit. A new write has to land on a register while the crossing already running on it, either a write or a read capture, is still between the two clock domains. The stimulus issues the second request on the very next bus cycle after the first. Because the peripheral clock is slower and each crossing takes several of its cycles, the collision is certain to happen. A second scenario starts two crossings back to back and reads the busy bitmap while both are in flight. It then checks that sync_ready sets only once, after the later of the two completes.

// File: rtl/wsb_pkg.sv
package wsb_pkg;
  typedef enum logic {
    OP_WR = 1'b0,
    OP_RD = 1'b1
  } xop_e;
endpackage

// File: rtl/wsb_sync2.sv
module wsb_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= 1'b0;
      q    <= 1'b0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/wsb_chan.sv
module wsb_chan
  import wsb_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          bus_clk,
  input  logic          bus_rst_n,
  input  logic          start,
  input  logic          start_rd,
  input  logic [DW-1:0] wdata,
  output logic          busy,
  output logic [DW-1:0] hold,
  output logic [DW-1:0] shadow,
  input  logic          core_clk,
  input  logic          core_rst_n,
  input  logic          core_ld,
  input  logic [DW-1:0] core_ld_data,
  output logic [DW-1:0] core_val
);
  // bus side
  logic    req_t, ack_s, ack_q;
  xop_e    op;
  // core side
  logic    ack_t, req_s, req_q;
  logic [DW-1:0] cap;

  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n) begin
      req_t <= 1'b0;
      op    <= OP_WR;
      hold  <= '0;
    end else if (start) begin
      req_t <= ~req_t;
      op    <= start_rd ? OP_RD : OP_WR;
      if (!start_rd) hold <= wdata;
    end
  end

  wsb_sync2 u_ack_sync (.clk(bus_clk), .rst_n(bus_rst_n), .d(ack_t), .q(ack_s));

  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n) begin
      ack_q  <= 1'b0;
      shadow <= '0;
    end else begin
      ack_q <= ack_s;
      if ((ack_s ^ ack_q) && op == OP_RD) shadow <= cap;
    end
  end

  // busy clears on the same edge that the shadow is refreshed
  assign busy = req_t ^ ack_q;

  wsb_sync2 u_req_sync (.clk(core_clk), .rst_n(core_rst_n), .d(req_t), .q(req_s));

  always_ff @(posedge core_clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      req_q    <= 1'b0;
      ack_t    <= 1'b0;
      cap      <= '0;
      core_val <= '0;
    end else begin
      req_q <= req_s;
      if (req_s ^ req_q) begin
        ack_t <= ~ack_t;
        if (op == OP_RD) begin
          cap <= core_val;
          if (core_ld) core_val <= core_ld_data;
        end else begin
          core_val <= hold;
        end
      end else if (core_ld) begin
        core_val <= core_ld_data;
      end
    end
  end
endmodule

// File: rtl/wsync_reg_bridge.sv
module wsync_reg_bridge #(
  parameter int          DW           = 16,
  parameter int          AW           = 4,
  parameter int          NSYNC        = 4,
  parameter int          NLOCAL       = 2,
  parameter logic [NSYNC-1:0] RD_SYNC_MASK = 4'b1100
) (
  input  logic                bus_clk,
  input  logic                bus_rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [AW-1:0]       req_addr,
  input  logic [DW-1:0]       req_wdata,
  output logic                rsp_valid,
  output logic [DW-1:0]       rsp_data,
  output logic [NSYNC-1:0]    busy,
  output logic                access_err,
  output logic                sync_ready,
  input  logic                core_clk,
  input  logic                core_rst_n,
  input  logic [NSYNC-1:0]    core_ld,
  input  logic [NSYNC*DW-1:0] core_ld_data,
  output logic [NSYNC*DW-1:0] core_regs
);
  localparam logic [AW-1:0] ADDR_BUSY = AW'((1 << AW) - 2);
  localparam logic [AW-1:0] ADDR_FLAG = AW'((1 << AW) - 1);

  logic [DW-1:0]    hold_a   [NSYNC];
  logic [DW-1:0]    shadow_a [NSYNC];
  logic [DW-1:0]    loc_a    [NLOCAL];
  logic [NSYNC-1:0] err_v;
  logic [NSYNC-1:0] busy_q;
  logic [DW-1:0]    rd_mux;
  logic             flag_set, flag_clr;

  assign req_ready = 1'b1;

  for (genvar i = 0; i < NSYNC; i++) begin : g_chan
    logic hit;
    assign hit      = req_valid && (req_addr == AW'(i));
    assign err_v[i] = hit && req_write && busy[i];

    wsb_chan #(.DW(DW)) u_chan (
      .bus_clk      (bus_clk),
      .bus_rst_n    (bus_rst_n),
      .start        (hit && !busy[i] && (req_write || RD_SYNC_MASK[i])),
      .start_rd     (!req_write),
      .wdata        (req_wdata),
      .busy         (busy[i]),
      .hold         (hold_a[i]),
      .shadow       (shadow_a[i]),
      .core_clk     (core_clk),
      .core_rst_n   (core_rst_n),
      .core_ld      (core_ld[i]),
      .core_ld_data (core_ld_data[i*DW +: DW]),
      .core_val     (core_regs[i*DW +: DW])
    );
  end

  for (genvar j = 0; j < NLOCAL; j++) begin : g_local
    always_ff @(posedge bus_clk or negedge bus_rst_n) begin
      if (!bus_rst_n) loc_a[j] <= '0;
      else if (req_valid && req_write && req_addr == AW'(NSYNC + j)) loc_a[j] <= req_wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NSYNC; i++)
      if (req_addr == AW'(i)) rd_mux = RD_SYNC_MASK[i] ? shadow_a[i] : hold_a[i];
    for (int j = 0; j < NLOCAL; j++)
      if (req_addr == AW'(NSYNC + j)) rd_mux = loc_a[j];
    if (req_addr == ADDR_BUSY) rd_mux = DW'(busy);
    if (req_addr == ADDR_FLAG) rd_mux = DW'(sync_ready);
  end

  assign flag_set = (|busy_q) && !(|busy);
  assign flag_clr = req_valid && req_write && req_addr == ADDR_FLAG && req_wdata[0];

  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n) begin
      busy_q     <= '0;
      sync_ready <= 1'b0;
      access_err <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
    end else begin
      busy_q     <= busy;
      sync_ready <= flag_set | (sync_ready & ~flag_clr);
      access_err <= |err_v;
      rsp_valid  <= req_valid && !req_write;
      if (req_valid && !req_write) rsp_data <= rd_mux;
    end
  end
endmodule

// File: rtl/wsync_reg_bridge_chk.sv
module wsync_reg_bridge_chk #(
  parameter int DW    = 16,
  parameter int AW    = 4,
  parameter int NSYNC = 4
) (
  input logic             bus_clk,
  input logic             bus_rst_n,
  input logic             req_valid,
  input logic             req_write,
  input logic [AW-1:0]    req_addr,
  input logic [DW-1:0]    req_wdata,
  input logic [NSYNC-1:0] busy,
  input logic             access_err,
  input logic             sync_ready,
  input logic             rsp_valid
);
  localparam logic [AW-1:0] ADDR_FLAG = AW'((1 << AW) - 1);

  AST_BUSY_AFTER_WRITE: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (req_valid && req_write && req_addr < AW'(NSYNC) && busy == '0) |=> (busy != '0)); // R1

  AST_ERR_NEEDS_BUSY: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    access_err |-> $past(busy != '0)); // R2

  AST_READY_ON_DRAIN: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    $rose(sync_ready) |-> $past(busy == '0)); // R3

  AST_FLAG_W1C: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (req_valid && req_write && req_addr == ADDR_FLAG && req_wdata[0] &&
     busy == '0 && $past(busy == '0)) |=> !sync_ready); // R3

  AST_RSP_AFTER_READ: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (req_valid && !req_write) |=> rsp_valid); // R10

  AST_RSP_ONLY_READ: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    rsp_valid |-> $past(req_valid && !req_write)); // R10
endmodule

bind wsync_reg_bridge wsync_reg_bridge_chk #(.DW(DW), .AW(AW), .NSYNC(NSYNC)) u_chk (
  .bus_clk    (bus_clk),
  .bus_rst_n  (bus_rst_n),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_addr   (req_addr),
  .req_wdata  (req_wdata),
  .busy       (busy),
  .access_err (access_err),
  .sync_ready (sync_ready),
  .rsp_valid  (rsp_valid)
);

// File: tb/wsync_reg_bridge_test.sv
`timescale 1ns/100ps
module wsync_reg_bridge_test;
  localparam int DW = 16, AW = 4, NSYNC = 4;

  logic bus_clk = 0, core_clk = 0, bus_rst_n = 0, core_rst_n = 0;
  logic req_valid = 0, req_write = 0, req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic rsp_valid, access_err, sync_ready;
  logic [DW-1:0] rsp_data;
  logic [NSYNC-1:0] busy;
  logic [NSYNC-1:0] core_ld = '0;
  logic [NSYNC*DW-1:0] core_ld_data = '0;
  logic [NSYNC*DW-1:0] core_regs;
  int checks = 0, fails = 0;
  logic [DW-1:0] rd;

  always #4 bus_clk = ~bus_clk;
  always #6.5 core_clk = ~core_clk;

  wsync_reg_bridge uut (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .busy(busy), .access_err(access_err),
    .sync_ready(sync_ready), .core_clk(core_clk), .core_rst_n(core_rst_n),
    .core_ld(core_ld), .core_ld_data(core_ld_data), .core_regs(core_regs));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] creg(input int i);
    return core_regs[i*DW +: DW];
  endfunction

  // drive at negedge, accepted at next posedge, return at following negedge
  task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge bus_clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge bus_clk);
    req_valid = 0;
    chk(rsp_valid === 1'b1, "R10 rsp_valid", rsp_valid, 1);
    d = rsp_data;
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 200 && busy != '0; n++) @(negedge bus_clk);
    chk(busy == '0, "R1 busy clears", busy, 0);
    @(negedge bus_clk);
  endtask

  task automatic clear_flag();
    bus_wr(AW'(15), 16'h0001);
  endtask

  task automatic t_reset();
    chk(busy == '0, "R9 busy", busy, 0);
    chk(!sync_ready, "R9 sync_ready", sync_ready, 0);
    chk(!access_err, "R9 access_err", access_err, 0);
    chk(!rsp_valid, "R9 rsp_valid", rsp_valid, 0);
    chk(core_regs == '0, "R9 core_regs", core_regs, 0);
    chk(req_ready, "R10 req_ready", req_ready, 1);
  endtask

  task automatic t_write_basic();
    bus_wr(0, 16'h1234);
    chk(busy == 4'b0001, "R1 busy set", busy, 1);
    chk(creg(0) == 16'h0, "R1 not yet landed", creg(0), 0);
    wait_idle();
    chk(creg(0) == 16'h1234, "R1 core copy", creg(0), 16'h1234);
    chk(sync_ready, "R3 flag set on drain", sync_ready, 1);
    bus_wr(AW'(15), 16'h0000);
    chk(sync_ready, "R3 write zero keeps flag", sync_ready, 1);
    bus_rd(AW'(15), rd);
    chk(rd == 16'h1, "R3 flag readable", rd, 1);
    clear_flag();
    chk(!sync_ready, "R3 W1C", sync_ready, 0);
    bus_rd(0, rd);
    chk(rd == 16'h1234 && busy == '0, "R4 write-only readback", rd, 16'h1234);
  endtask

  task automatic t_drop();
    bus_wr(1, 16'hAAAA);
    chk(!access_err, "R2 no err first", access_err, 0);
    bus_wr(1, 16'h5555);
    chk(access_err, "R2 err pulse", access_err, 1);
    @(negedge bus_clk);
    chk(!access_err, "R2 err one cycle", access_err, 0);
    wait_idle();
    chk(creg(1) == 16'hAAAA, "R2 dropped write", creg(1), 16'hAAAA);
    clear_flag();
  endtask

  task automatic t_concurrent();
    bus_wr(0, 16'h0F0F);
    bus_wr(1, 16'hF0F0);
    chk(busy == 4'b0011, "R7 both busy", busy, 3);
    bus_rd(AW'(14), rd);
    chk(rd[NSYNC-1:0] == 4'b0011, "R8 busy readable", rd, 3);
    chk(!sync_ready, "R3 not while busy", sync_ready, 0);
    wait_idle();
    chk(creg(0) == 16'h0F0F && creg(1) == 16'hF0F0, "R7 both landed",
        {creg(1), creg(0)}, 32'hF0F00F0F);
    chk(sync_ready, "R3 flag after both", sync_ready, 1);
    clear_flag();
  endtask

  task automatic t_readsync();
    @(negedge core_clk);
    core_ld[2] = 1; core_ld_data[2*DW +: DW] = 16'h0BEE;
    @(negedge core_clk);
    core_ld[2] = 0;
    chk(creg(2) == 16'h0BEE, "R11 core load", creg(2), 16'h0BEE);
    @(negedge bus_clk);
    bus_rd(2, rd);
    chk(rd == 16'h0, "R4 old shadow", rd, 0);
    chk(busy == 4'b0100, "R4 capture busy", busy, 4);
    bus_wr(2, 16'h1111);
    chk(access_err, "R5 write during read capture", access_err, 1);
    wait_idle();
    chk(creg(2) == 16'h0BEE, "R5 write dropped", creg(2), 16'h0BEE);
    bus_rd(2, rd);
    chk(rd == 16'h0BEE, "R4 captured value", rd, 16'h0BEE);
    wait_idle();
    clear_flag();
  endtask

  task automatic t_local();
    bus_wr(4, 16'hC0DE);
    chk(busy == '0, "R6 no busy", busy, 0);
    bus_wr(5, 16'hBEEF);
    bus_rd(4, rd);
    chk(rd == 16'hC0DE, "R6 local 4", rd, 16'hC0DE);
    bus_rd(5, rd);
    chk(rd == 16'hBEEF && busy == '0, "R6 local 5", rd, 16'hBEEF);
    chk(!sync_ready, "R6 no flag", sync_ready, 0);
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge bus_clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    report();
  end

  initial begin
    repeat (3) @(negedge bus_clk);
    bus_rst_n = 1; core_rst_n = 1;
    @(negedge bus_clk);
    t_reset();
    t_write_basic();
    t_drop();
    t_concurrent();
    t_readsync();
    t_local();
    report();
  end
endmodule